// File: doc/BRIEF.md
# Multi-Cycle 8-bit Mini Processor Core

This block is a small processor core that runs programs in a 16-opcode instruction set. Every instruction is one 16-bit word. It is held in memory as two bytes, the high byte at the lower address, and it starts at an even byte address. The core reads both bytes through a single synchronous byte port into a 4096-byte address space, decodes the opcode in the top four bits and executes the instruction. Each instruction takes four clock cycles: two byte reads, one cycle for the data to land, and one execute cycle in which registers, the program counter, the return stack or the memory are updated.

The sixteen 8-bit register slots are addressed by a 4-bit index. Indices 0x0 to 0xB are general-purpose registers. Index 0xC is the low byte of the 12-bit memory address register. Index 0xD is a delay countdown and index 0xE is a sound countdown; both are decremented by a 60 Hz tick input. Index 0xF is a scratch and flag register. Stores go to the memory address register plus an 8-bit offset. Subroutine return addresses are kept in an internal 16-entry stack. The core stops for good, with no error, when a jump targets its own address. It stops with an error when the stack is misused or when a fetch address is odd. Only a reset restarts it.

Top module: `mc8_core`

## Requirements
- R1: While reset is asserted `halted`, `error` and `mem_we` are 0. In the first cycle after release, `mem_addr` is 0x000, which fetches the high byte. In the next cycle it is 0x001, which fetches the low byte.
- R2: The opcode is bits 15..12, Rx is bits 11..8, Ry is bits 7..4 and the 8-bit immediate or offset is bits 7..0. Opcode 0x0 loads the immediate into Rx and opcode 0x1 copies Ry into Rx. After every instruction that does not branch, the PC advances by 2.
- R3: Opcodes 0x2 (add), 0x3 (subtract) and 0x4 (multiply) write the low 8 bits of Rx op Ry into Rx.
- R4: Opcode 0x5 writes Rx/Ry into Rx, and writes 0xFF when Ry is 0. Opcode 0x6 writes Rx mod Ry into register 0xF and leaves Rx unchanged; when Ry is 0 it writes Rx into register 0xF.
- R5: Opcode 0xD shifts Rx right by Ry, copying the sign bit in. Opcode 0xE shifts Rx left by Ry, filling with zeros. Both set register 0xF to 1 when the original bit 7 of Rx was 1 and to 0 otherwise. When Rx is 0xF, the flag value is the one kept.
- R6: Opcode 0x7 advances the PC by 4 when Rx equals Ry. Opcode 0x8 advances it by 4 when they differ. Otherwise both advance it by 2.
- R7: Opcode 0x9 loads bits 11..0 into the PC. A jump whose target equals its own address sets `halted` with `error` low.
- R8: Opcode 0xA pushes PC+2 onto a 16-entry stack and jumps to bits 11..0. Opcode 0xB pops the stack into the PC. Calls nest up to 16 deep.
- R9: A call while the stack holds 16 entries, or a return while it is empty, sets both `halted` and `error`.
- R10: A fetch from an odd PC sets both `halted` and `error` before any byte of that fetch is used.
- R11: Opcode 0xC loads bits 11..0 into the address register. Opcode 0xF writes Rx to the address register plus the zero-extended offset, modulo 4096. Register index 0xC reads and writes the low byte of the address register.
- R12: Registers 0xD and 0xE each decrement by 1 on every clock with `tick` high while they are non-zero. They stay at 0 and never change without a tick.
- R13: Once `halted` is 1, it and `error` hold their values and `mem_we` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 60 Hz that decrements the countdown registers |
| mem_addr | output | 12 | Byte address for a read or a write |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data for the address presented in the previous cycle |
| halted | output | 1 | Core stopped (self-jump or fault) |
| error | output | 1 | Core stopped because of a fault |

## Verification
The assertions assume three things about the inputs: `tick` is synchronous to `clk`, the memory returns a byte one cycle after its address, and the memory accepts a write in the same cycle as the strobe. The bench memory model is built to behave exactly that way. Test programs put their stores at 0x500 and above, so no program overwrites its own code. Countdown ticks are only sent while the program waits in a polling loop on register 0xD. This makes the number of decrements independent of how the ticks line up with instruction boundaries.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

   typedef enum logic [3:0] {
      OP_LDI  = 4'h0,
      OP_MOV  = 4'h1,
      OP_ADD  = 4'h2,
      OP_SUB  = 4'h3,
      OP_MUL  = 4'h4,
      OP_DIV  = 4'h5,
      OP_MOD  = 4'h6,
      OP_SKEQ = 4'h7,
      OP_SKNE = 4'h8,
      OP_JMP  = 4'h9,
      OP_CALL = 4'hA,
      OP_RET  = 4'hB,
      OP_LDA  = 4'hC,
      OP_SHR  = 4'hD,
      OP_SHL  = 4'hE,
      OP_STO  = 4'hF
   } op_e;

   typedef enum logic [2:0] {
      ST_FHI,
      ST_FLO,
      ST_LAND,
      ST_EXEC,
      ST_STOP,
      ST_FAULT
   } st_e;

endpackage

// File: rtl/mc8_alu.sv
module mc8_alu
   import mc8_pkg::*;
#(
   parameter int DW = 8
)(
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] res,
   output logic          a_msb
);

   logic [2*DW-1:0] prod;

   always_comb begin
      prod = a * b;
      unique case (op)
         OP_ADD:  res = a + b;
         OP_SUB:  res = a - b;
         OP_MUL:  res = prod[DW-1:0];
         OP_DIV:  res = (b == '0) ? '1 : a / b;
         OP_MOD:  res = (b == '0) ? a  : a % b;
         OP_SHR:  res = $signed(a) >>> b;
         OP_SHL:  res = a << b;
         default: res = b;
      endcase
   end

   assign a_msb = a[DW-1];

endmodule

// File: rtl/mc8_regfile.sv
module mc8_regfile #(
   parameter int IDX_W = 4,
   parameter int DW    = 8,
   parameter int AW    = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [IDX_W-1:0] ra_idx,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [DW-1:0]    ra,
   output logic [DW-1:0]    rb,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic             flg_en,
   input  logic [DW-1:0]    flg_data,
   input  logic             adr_en,
   input  logic [AW-1:0]    adr_data,
   output logic [AW-1:0]    adr
);

   localparam int NREG   = 1 << IDX_W;
   localparam int IDX_AR = NREG - 4;
   localparam int IDX_DL = NREG - 3;
   localparam int IDX_SN = NREG - 2;
   localparam int IDX_FL = NREG - 1;

   if (IDX_W < 3) begin : g_chk_idx
      $error("mc8_regfile: IDX_W too small for the special slots");
   end
   if (AW <= DW) begin : g_chk_aw
      $error("mc8_regfile: address register must be wider than a data byte");
   end

   logic [DW-1:0] rv [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         adr <= '0;
      else if (adr_en)
         adr <= adr_data;
      else if (wr_en && wr_idx == IDX_W'(IDX_AR))
         adr[DW-1:0] <= wr_data;
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == IDX_AR) begin : g_ar
         assign rv[i] = adr[DW-1:0];
      end else begin : g_q
         localparam bit IS_CNT = (i == IDX_DL) || (i == IDX_SN);
         localparam bit IS_FLG = (i == IDX_FL);
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (IS_FLG && flg_en)
               q <= flg_data;
            else if (wr_en && wr_idx == IDX_W'(i))
               q <= wr_data;
            else if (IS_CNT && tick && q != '0)
               q <= q - DW'(1);
         end
         assign rv[i] = q;
      end
   end

   assign ra = rv[ra_idx];
   assign rb = rv[rb_idx];

endmodule

// File: rtl/mc8_stack.sv
module mc8_stack #(
   parameter int DEPTH = 16,
   parameter int W     = 16,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  top,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);

   if ((1 << PW) != DEPTH || DEPTH < 2) begin : g_chk_depth
      $error("mc8_stack: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  slot [DEPTH];
   logic [CW-1:0] cnt_m1;

   assign cnt_m1 = count - CW'(1);
   assign top    = slot[cnt_m1[PW-1:0]];
   assign full   = (count == CW'(DEPTH));
   assign empty  = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
      end else if (push && !full) begin
         slot[count[PW-1:0]] <= din;
         count <= count + CW'(1);
      end else if (pop && !empty) begin
         count <= cnt_m1;
      end
   end

endmodule

// File: rtl/mc8_core.sv
module mc8_core
   import mc8_pkg::*;
#(
   parameter int AW        = 12,
   parameter int DW        = 8,
   parameter int PCW       = 16,
   parameter int STK_DEPTH = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          halted,
   output logic          error
);

   localparam int IW     = 2 * DW;
   localparam int OPW    = 4;
   localparam int IXW    = 4;
   localparam int STK_CW = $clog2(STK_DEPTH + 1);

   if (DW != 8) begin : g_chk_dw
      $error("mc8_core: instruction fields assume 8-bit bytes");
   end
   if (AW != IW - OPW) begin : g_chk_aw
      $error("mc8_core: address field must fill the non-opcode bits");
   end
   if (PCW < AW) begin : g_chk_pc
      $error("mc8_core: program counter narrower than the address space");
   end

   st_e             st, st_nx;
   logic [PCW-1:0]  pc, pc_nx, pc_seq;
   logic [IW-1:0]   ir;
   op_e             op;
   logic [IXW-1:0]  rx, ry;
   logic [DW-1:0]   imm;
   logic [PCW-1:0]  tgt;

   assign op     = op_e'(ir[IW-1 -: OPW]);
   assign rx     = ir[IW-OPW-1 -: IXW];
   assign ry     = ir[IW-OPW-IXW-1 -: IXW];
   assign imm    = ir[DW-1:0];
   assign tgt    = PCW'(ir[AW-1:0]);
   assign pc_seq = pc + PCW'(2);

   logic           rf_we, fl_we, ar_we, st_we;
   logic [DW-1:0]  rf_wd, fl_wd, ra, rb, alu_res;
   logic           alu_msb;
   logic [AW-1:0]  ar;
   logic           s_push, s_pop, s_full, s_empty;
   logic [PCW-1:0] s_top;
   logic [STK_CW-1:0] stk_cnt;

   mc8_regfile #(.IDX_W(IXW), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ra_idx(rx), .rb_idx(ry), .ra(ra), .rb(rb),
      .wr_en(rf_we), .wr_idx(rx), .wr_data(rf_wd),
      .flg_en(fl_we), .flg_data(fl_wd),
      .adr_en(ar_we), .adr_data(ir[AW-1:0]), .adr(ar)
   );

   mc8_alu #(.DW(DW)) u_alu (
      .op(op), .a(ra), .b(rb), .res(alu_res), .a_msb(alu_msb)
   );

   mc8_stack #(.DEPTH(STK_DEPTH), .W(PCW)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(s_push), .pop(s_pop), .din(pc_seq),
      .top(s_top), .full(s_full), .empty(s_empty), .count(stk_cnt)
   );

   always_comb begin
      rf_we  = 1'b0;
      rf_wd  = alu_res;
      fl_we  = 1'b0;
      fl_wd  = alu_res;
      ar_we  = 1'b0;
      st_we  = 1'b0;
      s_push = 1'b0;
      s_pop  = 1'b0;
      pc_nx  = pc_seq;
      st_nx  = ST_FHI;
      if (st == ST_EXEC) begin
         unique case (op)
            OP_LDI: begin
               rf_we = 1'b1;
               rf_wd = imm;
            end
            OP_MOV, OP_ADD, OP_SUB, OP_MUL, OP_DIV: rf_we = 1'b1;
            OP_MOD: fl_we = 1'b1;
            OP_SKEQ: if (ra == rb) pc_nx = pc + PCW'(4);
            OP_SKNE: if (ra != rb) pc_nx = pc + PCW'(4);
            OP_JMP: begin
               pc_nx = tgt;
               if (tgt == pc) st_nx = ST_STOP;
            end
            OP_CALL: begin
               if (s_full) begin
                  st_nx = ST_FAULT;
                  pc_nx = pc;
               end else begin
                  s_push = 1'b1;
                  pc_nx  = tgt;
               end
            end
            OP_RET: begin
               if (s_empty) begin
                  st_nx = ST_FAULT;
                  pc_nx = pc;
               end else begin
                  s_pop = 1'b1;
                  pc_nx = s_top;
               end
            end
            OP_LDA: ar_we = 1'b1;
            OP_SHR, OP_SHL: begin
               rf_we = 1'b1;
               fl_we = 1'b1;
               fl_wd = {{(DW-1){1'b0}}, alu_msb};
            end
            OP_STO: st_we = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_FHI;
         pc <= '0;
         ir <= '0;
      end else begin
         unique case (st)
            ST_FHI:  st <= pc[0] ? ST_FAULT : ST_FLO;
            ST_FLO: begin
               ir[IW-1:DW] <= mem_rdata;
               st <= ST_LAND;
            end
            ST_LAND: begin
               ir[DW-1:0] <= mem_rdata;
               st <= ST_EXEC;
            end
            ST_EXEC: begin
               pc <= pc_nx;
               st <= st_nx;
            end
            default: st <= st;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         ST_FLO:  mem_addr = pc[AW-1:0] | AW'(1);
         ST_EXEC: mem_addr = st_we ? ar + AW'(imm) : pc[AW-1:0];
         default: mem_addr = pc[AW-1:0];
      endcase
   end

   assign mem_we    = st_we;
   assign mem_wdata = ra;
   assign halted    = (st == ST_STOP) || (st == ST_FAULT);
   assign error     = (st == ST_FAULT);

endmodule

// File: rtl/mc8_core_chk.sv
module mc8_core_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
)(
   input logic          clk,
   input logic          rst_n,
   input logic          mem_we,
   input logic          halted,
   input logic          error,
   input logic [CW-1:0] stk_cnt
);

   // R13
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R13
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   // R13
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   // R9
   err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> halted);

   // R8
   stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_cnt <= CW'(DEPTH));

   // R8
   stk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_cnt == $past(stk_cnt)) || (stk_cnt == $past(stk_cnt) + CW'(1))
      || (stk_cnt + CW'(1) == $past(stk_cnt)));

   // R11
   wr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

endmodule

bind mc8_core mc8_core_chk #(.DEPTH(STK_DEPTH), .CW(STK_CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .halted(halted),
   .error(error), .stk_cnt(stk_cnt)
);

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        halted, error;

   logic [7:0]  mem [4096];
   logic [15:0] lp;
   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mc8_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .halted(halted), .error(error)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   // op, a, b, expected Rx, expected reg 0xF
   localparam int NV = 13;
   localparam logic [35:0] VEC [NV] = '{
      {4'h2, 8'h05, 8'h03, 8'h08, 8'h00},
      {4'h2, 8'hF0, 8'h20, 8'h10, 8'h00},
      {4'h3, 8'h03, 8'h05, 8'hFE, 8'h00},
      {4'h4, 8'h12, 8'h10, 8'h20, 8'h00},
      {4'h5, 8'hC8, 8'h07, 8'h1C, 8'h00},
      {4'h5, 8'h09, 8'h00, 8'hFF, 8'h00},
      {4'h6, 8'hC8, 8'h07, 8'hC8, 8'h04},
      {4'h6, 8'h09, 8'h00, 8'h09, 8'h09},
      {4'hD, 8'h84, 8'h02, 8'hE1, 8'h01},
      {4'hD, 8'h44, 8'h01, 8'h22, 8'h00},
      {4'hE, 8'h81, 8'h01, 8'h02, 8'h01},
      {4'hE, 8'h11, 8'h03, 8'h88, 8'h00},
      {4'h1, 8'h33, 8'h77, 8'h77, 8'h00}
   };

   function automatic logic [15:0] rr(input logic [3:0] o, x, y);
      return {o, x, y, 4'h0};
   endfunction
   function automatic logic [15:0] ri(input logic [3:0] o, x, input logic [7:0] v);
      return {o, x, v};
   endfunction
   function automatic logic [15:0] ad(input logic [3:0] o, input logic [11:0] a);
      return {o, a};
   endfunction
   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'h2, 4'h3, 4'h4: return "R3";
         4'h5, 4'h6:       return "R4";
         4'hD, 4'hE:       return "R5";
         default:          return "R2";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] w);
      mem[lp[11:0]]         = w[15:8];
      mem[lp[11:0] + 12'd1] = w[7:0];
      lp = lp + 16'd2;
   endtask
   task automatic jself();
      put(ad(4'h9, lp[11:0]));
   endtask

   task automatic begin_test();
      @(negedge clk);
      rst_n = 1'b0;
      tick  = 1'b0;
      for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
      lp = 16'h0000;
   endtask

   task automatic release_rst();
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic wait_halt(input string req);
      int n = 0;
      while (!halted && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check(req, {15'd0, halted}, 16'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state and first fetch addresses
      begin_test();
      put(ri(4'h0, 4'h1, 8'h5A));
      put(ad(4'hC, 12'h500));
      put(ri(4'hF, 4'h1, 8'h00));
      jself();
      @(negedge clk);
      check("R1 halted in reset", {15'd0, halted}, 16'd0);
      check("R1 error in reset", {15'd0, error}, 16'd0);
      check("R1 we in reset", {15'd0, mem_we}, 16'd0);
      release_rst();
      check("R1 first fetch addr", {4'd0, mem_addr}, 16'h000);
      @(negedge clk);
      check("R1 second fetch addr", {4'd0, mem_addr}, 16'h001);
      wait_halt("R7 self jump halts");
      check("R7 self jump no error", {15'd0, error}, 16'd0);
      check("R2 load imm stored", {8'd0, mem[12'h500]}, 16'h005A);
      // R13: stopped core stays stopped and quiet
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         check("R13 quiet after halt", {14'd0, halted, mem_we}, 16'd2);
      end

      // R2 R3 R4 R5: vector table of ALU programs
      for (int i = 0; i < NV; i++) begin
         logic [3:0] o;
         o = VEC[i][35:32];
         begin_test();
         put(ri(4'h0, 4'h1, VEC[i][31:24]));
         put(ri(4'h0, 4'h2, VEC[i][23:16]));
         put(rr(o, 4'h1, 4'h2));
         put(ad(4'hC, 12'h500));
         put(ri(4'hF, 4'h1, 8'h00));
         put(ri(4'hF, 4'hF, 8'h01));
         jself();
         release_rst();
         wait_halt(tag_of(o));
         check(tag_of(o), {8'd0, mem[12'h500]}, {8'd0, VEC[i][15:8]});
         check(tag_of(o), {8'd0, mem[12'h501]}, {8'd0, VEC[i][7:0]});
      end

      // R5: flag write wins when destination is register 0xF
      begin_test();
      put(ri(4'h0, 4'hF, 8'h90));
      put(ri(4'h0, 4'h2, 8'h01));
      put(rr(4'hE, 4'hF, 4'h2));
      put(ad(4'hC, 12'h500));
      put(ri(4'hF, 4'hF, 8'h00));
      jself();
      release_rst();
      wait_halt("R5");
      check("R5 flag over shift", {8'd0, mem[12'h500]}, 16'h0001);

      // R6: skip-equal and skip-not-equal
      begin_test();
      put(ri(4'h0, 4'h1, 8'h05));
      put(ri(4'h0, 4'h2, 8'h05));
      put(rr(4'h7, 4'h1, 4'h2));
      put(ri(4'h0, 4'h3, 8'hAA));
      put(ri(4'h0, 4'h4, 8'h11));
      put(rr(4'h8, 4'h1, 4'h2));
      put(ri(4'h0, 4'h5, 8'h22));
      put(ri(4'h0, 4'h6, 8'h07));
      put(rr(4'h8, 4'h1, 4'h6));
      put(ri(4'h0, 4'h7, 8'h99));
      put(ad(4'hC, 12'h500));
      put(ri(4'hF, 4'h3, 8'h00));
      put(ri(4'hF, 4'h4, 8'h01));
      put(ri(4'hF, 4'h5, 8'h02));
      put(ri(4'hF, 4'h7, 8'h03));
      jself();
      release_rst();
      wait_halt("R6");
      check("R6 equal skips", {8'd0, mem[12'h500]}, 16'h0000);
      check("R6 after skip runs", {8'd0, mem[12'h501]}, 16'h0011);
      check("R6 not-equal no skip", {8'd0, mem[12'h502]}, 16'h0022);
      check("R6 differ skips", {8'd0, mem[12'h503]}, 16'h0000);

      // R8: nested call and return
      begin_test();
      put(ad(4'hA, 12'h020));
      put(ad(4'hC, 12'h500));
      put(ri(4'hF, 4'h1, 8'h00));
      put(ri(4'hF, 4'h2, 8'h01));
      jself();
      lp = 16'h0020;
      put(ri(4'h0, 4'h1, 8'h5A));
      put(ad(4'hA, 12'h030));
      put(ad(4'hB, 12'h000));
      lp = 16'h0030;
      put(ri(4'h0, 4'h2, 8'h6B));
      put(ad(4'hB, 12'h000));
      release_rst();
      wait_halt("R8");
      check("R8 nested error", {15'd0, error}, 16'd0);
      check("R8 outer body", {8'd0, mem[12'h500]}, 16'h005A);
      check("R8 inner body", {8'd0, mem[12'h501]}, 16'h006B);

      // R11: offset carry, low-byte access to the address register
      begin_test();
      put(ad(4'hC, 12'h5F0));
      put(ri(4'h0, 4'h1, 8'h3C));
      put(ri(4'hF, 4'h1, 8'h20));
      put(ri(4'h0, 4'hC, 8'h10));
      put(ri(4'hF, 4'h1, 8'h00));
      put(rr(4'h1, 4'h2, 4'hC));
      put(ri(4'hF, 4'h2, 8'h01));
      jself();
      release_rst();
      wait_halt("R11");
      check("R11 base+offset carry", {8'd0, mem[12'h610]}, 16'h003C);
      check("R11 low byte write", {8'd0, mem[12'h510]}, 16'h003C);
      check("R11 low byte read", {8'd0, mem[12'h511]}, 16'h0010);

      // R9: seventeenth nested call faults
      begin_test();
      put(ad(4'hA, 12'h000));
      release_rst();
      wait_halt("R9 overflow");
      check("R9 overflow error", {15'd0, error}, 16'd1);

      // R9: return on empty stack faults
      begin_test();
      put(ad(4'hB, 12'h000));
      release_rst();
      wait_halt("R9 underflow");
      check("R9 underflow error", {15'd0, error}, 16'd1);

      // R10: odd fetch faults, the odd instruction never runs
      begin_test();
      put(ad(4'hC, 12'h500));
      put(ad(4'h9, 12'h005));
      mem[12'h005] = 8'hF1;
      mem[12'h006] = 8'h00;
      release_rst();
      wait_halt("R10");
      check("R10 odd fetch error", {15'd0, error}, 16'd1);
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         check("R13 fault holds", {14'd0, halted, error}, 16'd3);
      end

      // R12: countdowns saturate at zero and move only on tick
      begin_test();
      put(ri(4'h0, 4'hD, 8'h03));
      put(ri(4'h0, 4'hE, 8'h07));
      put(ad(4'hC, 12'h500));
      put(ri(4'hF, 4'h0, 8'h00));
      put(rr(4'h7, 4'hD, 4'h0));
      put(ad(4'h9, 12'h008));
      put(ri(4'hF, 4'hD, 8'h01));
      put(ri(4'hF, 4'hE, 8'h02));
      put(ri(4'h0, 4'hD, 8'h09));
      put(ri(4'hF, 4'hD, 8'h03));
      jself();
      release_rst();
      begin
         int n = 0;
         while (!(mem_we && mem_addr == 12'h500) && n < 200) begin
            @(negedge clk);
            n++;
         end
         check("R12 marker seen", {15'd0, mem_we}, 16'd1);
      end
      tick = 1'b1;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      wait_halt("R12");
      check("R12 delay stops at zero", {8'd0, mem[12'h501]}, 16'h0000);
      check("R12 sound counted down", {8'd0, mem[12'h502]}, 16'h0002);
      check("R12 no tick no change", {8'd0, mem[12'h503]}, 16'h0009);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule